// File: doc/BRIEF.md
# Branch and Skip Resolution Unit

This unit resolves conditional control flow for a small 8-bit processor core. It covers three instruction forms. A two-byte short branch keeps the high program-counter byte and loads the low byte from its immediate operand. A three-byte long branch loads a full 16-bit target from its two operand bytes, or else steps past them. A long skip moves the program counter ahead by two without reading any target. The unit does not access memory and holds no register file. The core's fetch logic hands it a request holding the opcode, the current program counter and the operand bytes already read. The unit returns the next program-counter value, a taken indication and a flag that says whether a third instruction byte belongs to the instruction.

The program counter given with a request is the address of the first operand byte, which is the value the core's program counter holds during the execute cycle. The condition flags (accumulator zero, carry, output flag, interrupt enable) are plain level inputs and are sampled when a request is accepted. The four external flag pins are active low. They are captured into an internal register only on cycles where the machine-cycle strobe is high, and the decision always uses that captured copy.

Requests enter on a valid/ready channel and results leave on a valid/ready channel, through one output register. The input is ready whenever the output register is empty or is being emptied in the same cycle. A result that is not taken stays unchanged on the outputs until the consumer accepts it.

Top module: `bsr_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, out_valid is 0 and in_ready is 1. Reset also clears the captured external flags to the not-asserted state.
- R2: in_ready equals (not out_valid) or out_ready. A request accepted on a clock edge (in_valid and in_ready both high) shows on the outputs with out_valid high right after that edge. While out_valid is high and out_ready is low, out_valid, out_next_pc, out_taken and out_third stay unchanged.
- R3: A taken short branch (opcodes 0x30 to 0x3F) gives out_next_pc = {in_pc[15:8], in_imm_a}, with out_taken = 1 and out_third = 0.
- R4: A short branch that is not taken gives out_next_pc = in_pc + 1, a full 16-bit increment that carries into the high byte, with out_taken = 0 and out_third = 0.
- R5: For a short branch, opcode bits [2:0] pick the condition: 0 always true, 1 output flag Q set, 2 accumulator zero, 3 carry set, 4 to 7 external flag 1 to 4 asserted. Opcode bit 3 set inverts the condition, so 0x38 is never taken. out_taken reports the result.
- R6: Long branches are 0xC0 (always), 0xC1 (Q=1), 0xC2 (accumulator zero), 0xC3 (carry=1), 0xC9 (Q=0), 0xCA (accumulator nonzero) and 0xCB (carry=0). When taken, out_next_pc = {in_imm_a, in_imm_b}. When not taken, out_next_pc = in_pc + 2. out_third is 1 for all of them.
- R7: Long skips are 0xC8 (always), 0xC5 (Q=0), 0xC6 (accumulator nonzero), 0xC7 (carry=0), 0xCC (interrupt enable=1), 0xCD (Q=1), 0xCE (accumulator zero) and 0xCF (carry=1). When taken, out_next_pc = in_pc + 2. When not taken, out_next_pc = in_pc. out_third is 0.
- R8: Opcode 0xC4 and every opcode outside 0x30 to 0x3F and 0xC0 to 0xCF give out_next_pc = in_pc, out_taken = 0 and out_third = 0.
- R9: External flag n is asserted when ext_flag_n[n-1] is 0. The pins are captured only on a rising clock edge where flag_strobe is 1, and a request accepted on that same edge still uses the previous capture. A pin change with no strobe has no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flag_strobe | input | 1 | Machine-cycle strobe that captures the external flag pins |
| ext_flag_n | input | 4 | External flag pins, active low |
| q_flag | input | 1 | Output flag Q |
| carry | input | 1 | Carry flag |
| acc_zero | input | 1 | Accumulator is zero |
| irq_en | input | 1 | Interrupt enable |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_opcode | input | 8 | Instruction opcode |
| in_pc | input | 16 | Address of the first operand byte |
| in_imm_a | input | 8 | First operand byte (target low byte for short, target high byte for long) |
| in_imm_b | input | 8 | Second operand byte (target low byte for long branches) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_next_pc | output | 16 | Resolved next program counter |
| out_taken | output | 1 | Branch or skip taken |
| out_third | output | 1 | Instruction carries a third byte (long branch) |

## Verification
On every cycle, the assertions check the handshake rules: the hold under back-pressure, and a result appearing after each accepted request. Against the request the checker captured, they also check the address arithmetic: the short-branch low-byte replacement, the increment when not taken, the long-branch target and third-byte flag, the unchanged PC for an idle skip, and non-control opcodes. The choice of condition per opcode, the inversion by bit 3 and the strobe-gated capture of the active-low external flags are shown only by the bench. Its reference model sweeps every opcode under changing flag values and strobe timing.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int OP_W = 8;

  typedef enum logic [1:0] {
    FORM_NONE,
    FORM_SHORT,
    FORM_LONG_BR,
    FORM_LONG_SKIP
  } bsr_form_e;

  typedef enum logic [2:0] {
    TEST_ALWAYS,
    TEST_Q,
    TEST_ACC_ZERO,
    TEST_CARRY,
    TEST_EXT,
    TEST_IRQ_EN
  } bsr_test_e;

  typedef struct packed {
    bsr_form_e  form;
    bsr_test_e  test;
    logic [1:0] ext_sel;
    logic       invert;
  } bsr_dec_t;
endpackage

// File: rtl/bsr_flag_sync.sv
// Captures the active-low external flag pins once per machine cycle.
module bsr_flag_sync #(
  parameter int NUM_EXT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_en,
  input  logic [NUM_EXT-1:0] pin_n,
  output logic [NUM_EXT-1:0] level
);
  for (genvar gi = 0; gi < NUM_EXT; gi++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        level[gi] <= 1'b0;
      end else if (sample_en) begin
        level[gi] <= ~pin_n[gi];
      end
    end
  end
endmodule

// File: rtl/bsr_decode.sv
// Opcode classification: instruction form, condition, and sense.
module bsr_decode
  import bsr_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output bsr_dec_t        dec
);
  function automatic bsr_test_e pick_flag(input logic [1:0] sel);
    case (sel)
      2'b01:   return TEST_Q;
      2'b10:   return TEST_ACC_ZERO;
      2'b11:   return TEST_CARRY;
      default: return TEST_ALWAYS;
    endcase
  endfunction

  always_comb begin
    dec.form    = FORM_NONE;
    dec.test    = TEST_ALWAYS;
    dec.ext_sel = opcode[1:0];
    dec.invert  = 1'b0;
    case (opcode[7:4])
      4'h3: begin
        dec.form   = FORM_SHORT;
        dec.invert = opcode[3];
        dec.test   = opcode[2] ? TEST_EXT : pick_flag(opcode[1:0]);
      end
      4'hC: begin
        if (!opcode[2]) begin
          if (opcode[1:0] == 2'b00) begin
            // unconditional long branch, or unconditional long skip
            dec.form = opcode[3] ? FORM_LONG_SKIP : FORM_LONG_BR;
          end else begin
            dec.form   = FORM_LONG_BR;
            dec.test   = pick_flag(opcode[1:0]);
            dec.invert = opcode[3];
          end
        end else begin
          if (opcode[1:0] == 2'b00) begin
            if (opcode[3]) begin
              dec.form = FORM_LONG_SKIP;
              dec.test = TEST_IRQ_EN;
            end
          end else begin
            // lower half skips on a false flag, upper half on a true flag
            dec.form   = FORM_LONG_SKIP;
            dec.test   = pick_flag(opcode[1:0]);
            dec.invert = ~opcode[3];
          end
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bsr_cond_eval.sv
// Selects the tested flag and applies the sense inversion.
module bsr_cond_eval
  import bsr_pkg::*;
#(
  parameter int NUM_EXT = 4
) (
  input  bsr_test_e          test,
  input  logic [1:0]         ext_sel,
  input  logic               invert,
  input  logic               q_flag,
  input  logic               acc_zero,
  input  logic               carry,
  input  logic               irq_en,
  input  logic [NUM_EXT-1:0] ext_level,
  output logic               cond_met
);
  logic raw;

  always_comb begin
    case (test)
      TEST_Q:        raw = q_flag;
      TEST_ACC_ZERO: raw = acc_zero;
      TEST_CARRY:    raw = carry;
      TEST_EXT:      raw = ext_level[ext_sel];
      TEST_IRQ_EN:   raw = irq_en;
      default:       raw = 1'b1;
    endcase
    cond_met = raw ^ invert;
  end
endmodule

// File: rtl/bsr_target.sv
// Next program-counter arithmetic for each form and outcome.
module bsr_target
  import bsr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  bsr_form_e         form,
  input  logic              taken,
  input  logic [ADDR_W-1:0] pc,
  input  logic [BYTE_W-1:0] imm_a,
  input  logic [BYTE_W-1:0] imm_b,
  output logic [ADDR_W-1:0] next_pc
);
  localparam logic [ADDR_W-1:0] STEP_ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] STEP_TWO = ADDR_W'(2);

  logic [ADDR_W-1:0] pc_inc1;
  logic [ADDR_W-1:0] pc_inc2;

  assign pc_inc1 = pc + STEP_ONE;
  assign pc_inc2 = pc + STEP_TWO;

  always_comb begin
    case (form)
      FORM_SHORT:     next_pc = taken ? {pc[ADDR_W-1:BYTE_W], imm_a} : pc_inc1;
      FORM_LONG_BR:   next_pc = taken ? ADDR_W'({imm_a, imm_b}) : pc_inc2;
      FORM_LONG_SKIP: next_pc = taken ? pc_inc2 : pc;
      default:        next_pc = pc;
    endcase
  end
endmodule

// File: rtl/bsr_unit.sv
module bsr_unit
  import bsr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BYTE_W  = 8,
  parameter int NUM_EXT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flag_strobe,
  input  logic [NUM_EXT-1:0] ext_flag_n,
  input  logic               q_flag,
  input  logic               carry,
  input  logic               acc_zero,
  input  logic               irq_en,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [OP_W-1:0]    in_opcode,
  input  logic [ADDR_W-1:0]  in_pc,
  input  logic [BYTE_W-1:0]  in_imm_a,
  input  logic [BYTE_W-1:0]  in_imm_b,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  out_next_pc,
  output logic               out_taken,
  output logic               out_third
);
  bsr_dec_t          dec;
  logic [NUM_EXT-1:0] ext_level;
  logic              cond_met;
  logic              taken_c;
  logic [ADDR_W-1:0] next_pc_c;
  logic              accept;

  bsr_flag_sync #(.NUM_EXT(NUM_EXT)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_en(flag_strobe),
    .pin_n    (ext_flag_n),
    .level    (ext_level)
  );

  bsr_decode u_dec (
    .opcode(in_opcode),
    .dec   (dec)
  );

  bsr_cond_eval #(.NUM_EXT(NUM_EXT)) u_cond (
    .test     (dec.test),
    .ext_sel  (dec.ext_sel),
    .invert   (dec.invert),
    .q_flag   (q_flag),
    .acc_zero (acc_zero),
    .carry    (carry),
    .irq_en   (irq_en),
    .ext_level(ext_level),
    .cond_met (cond_met)
  );

  assign taken_c = (dec.form != FORM_NONE) && cond_met;

  bsr_target #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_tgt (
    .form   (dec.form),
    .taken  (taken_c),
    .pc     (in_pc),
    .imm_a  (in_imm_a),
    .imm_b  (in_imm_b),
    .next_pc(next_pc_c)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_next_pc <= '0;
      out_taken   <= 1'b0;
      out_third   <= 1'b0;
    end else if (accept) begin
      out_next_pc <= next_pc_c;
      out_taken   <= taken_c;
      out_third   <= (dec.form == FORM_LONG_BR);
    end
  end
endmodule

// File: rtl/bsr_unit_chk.sv
module bsr_unit_chk #(
  parameter int ADDR_W  = 16,
  parameter int BYTE_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [7:0]        in_opcode,
  input logic [ADDR_W-1:0] in_pc,
  input logic [BYTE_W-1:0] in_imm_a,
  input logic [BYTE_W-1:0] in_imm_b,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_next_pc,
  input logic              out_taken,
  input logic              out_third
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  logic [7:0]        cap_op;
  logic [ADDR_W-1:0] cap_pc;
  logic [BYTE_W-1:0] cap_a;
  logic [BYTE_W-1:0] cap_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_op <= 8'h00;
      cap_pc <= '0;
      cap_a  <= '0;
      cap_b  <= '0;
    end else if (in_valid && in_ready) begin
      cap_op <= in_opcode;
      cap_pc <= in_pc;
      cap_a  <= in_imm_a;
      cap_b  <= in_imm_b;
    end
  end

  logic is_short, is_lbr, is_skip, is_other;
  assign is_short = (cap_op[7:4] == 4'h3);
  assign is_lbr   = cap_op inside {8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC9, 8'hCA, 8'hCB};
  assign is_skip  = cap_op inside {8'hC5, 8'hC6, 8'hC7, 8'hC8, 8'hCC, 8'hCD, 8'hCE, 8'hCF};
  assign is_other = !is_short && !is_lbr && !is_skip;

  a_r1_reset_idle: assert property (@(posedge clk) !rst_n |=> !out_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_next_pc) && $stable(out_taken) && $stable(out_third));

  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  a_r3_short_taken: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && is_short && out_taken |-> out_next_pc == {cap_pc[ADDR_W-1:BYTE_W], cap_a} && !out_third);

  a_r4_short_fall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && is_short && !out_taken |-> out_next_pc == cap_pc + ONE && !out_third);

  a_r6_long_taken: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && is_lbr && out_taken |-> out_next_pc == ADDR_W'({cap_a, cap_b}));

  a_r6_long_fall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && is_lbr && !out_taken |-> out_next_pc == cap_pc + TWO);

  a_r6_third: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_third == is_lbr);

  a_r7_skip: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && is_skip |-> out_next_pc == (out_taken ? cap_pc + TWO : cap_pc));

  a_r8_other: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && is_other |-> !out_taken && out_next_pc == cap_pc);
endmodule

bind bsr_unit bsr_unit_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/bsr_unit_tb_top.sv
module bsr_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flag_strobe = 1'b0;
  logic [3:0]  ext_flag_n = 4'hF;
  logic        q_flag = 1'b0, carry = 1'b0, acc_zero = 1'b0, irq_en = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_opcode = 8'h00;
  logic [15:0] in_pc = 16'h0000;
  logic [7:0]  in_imm_a = 8'h00, in_imm_b = 8'h00;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_next_pc;
  logic        out_taken, out_third;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  bsr_unit dut_i (.*);

  // ---------------- reference model ----------------
  typedef struct packed { logic taken; logic third; logic [15:0] pc; } res_t;

  logic [3:0] m_ext;
  logic       m_valid;
  res_t       m_res;
  logic [7:0] m_op;

  function automatic res_t ref_resolve(input logic [7:0] op, input logic [15:0] pc,
                                       input logic [7:0] a, input logic [7:0] b,
                                       input logic q, input logic z, input logic df,
                                       input logic ie, input logic [3:0] ef);
    res_t r;
    bit c;
    r.taken = 0; r.third = 0; r.pc = pc;
    if (op >= 8'h30 && op <= 8'h3F) begin
      case (op & 8'h07)
        0: c = 1;
        1: c = q;
        2: c = z;
        3: c = df;
        default: c = ef[op % 4];
      endcase
      if (op >= 8'h38) c = !c;
      r.taken = c;
      r.pc = c ? {pc[15:8], a} : pc + 16'd1;
    end else begin
      case (op)
        8'hC0: begin r.third = 1; c = 1;   end
        8'hC1: begin r.third = 1; c = q;   end
        8'hC2: begin r.third = 1; c = z;   end
        8'hC3: begin r.third = 1; c = df;  end
        8'hC9: begin r.third = 1; c = !q;  end
        8'hCA: begin r.third = 1; c = !z;  end
        8'hCB: begin r.third = 1; c = !df; end
        default: c = 0;
      endcase
      if (r.third) begin
        r.taken = c;
        r.pc = c ? {a, b} : pc + 16'd2;
      end else begin
        case (op)
          8'hC8: c = 1;
          8'hC5: c = !q;
          8'hC6: c = !z;
          8'hC7: c = !df;
          8'hCC: c = ie;
          8'hCD: c = q;
          8'hCE: c = z;
          8'hCF: c = df;
          default: c = 0;
        endcase
        r.taken = c;
        r.pc = c ? pc + 16'd2 : pc;
      end
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [7:0] op, input logic tk);
    if (op >= 8'h30 && op <= 8'h3F) begin
      if (op[2]) return "R9";
      return tk ? "R3" : "R4";
    end
    if (op inside {8'hC0, 8'hC1, 8'hC2, 8'hC3, 8'hC9, 8'hCA, 8'hCB}) return "R6";
    if (op inside {8'hC5, 8'hC6, 8'hC7, 8'hC8, 8'hCC, 8'hCD, 8'hCE, 8'hCF}) return "R7";
    return "R8";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_ext   <= 4'h0;
      m_res   <= '0;
      m_op    <= 8'h00;
    end else begin
      if (flag_strobe) m_ext <= ~ext_flag_n;
      if (in_valid && (!m_valid || out_ready)) begin
        m_valid <= 1'b1;
        m_op    <= in_opcode;
        m_res   <= ref_resolve(in_opcode, in_pc, in_imm_a, in_imm_b,
                               q_flag, acc_zero, carry, irq_en, m_ext);
      end else if (out_ready) begin
        m_valid <= 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, got, exp, cycles);
    end
  endtask

  // compare on every clock, away from the edge
  always @(posedge clk) begin
    cycles++;
    #2;
    if (rst_n) begin
      chk("R2 valid", 32'(out_valid), 32'(m_valid));
      chk("R2 ready", 32'(in_ready), 32'(!m_valid || out_ready));
      if (m_valid && out_valid) begin
        chk({tag_of(m_op, m_res.taken), " next_pc"}, 32'(out_next_pc), 32'(m_res.pc));
        chk({(m_op[7:4] == 4'h3) ? "R5" : tag_of(m_op, m_res.taken), " taken"},
            32'(out_taken), 32'(m_res.taken));
        chk("R6 third", 32'(out_third), 32'(m_res.third));
      end
    end
  end

  // ---------------- stimulus ----------------
  // Drives a request; returns just after the edge that accepted it.
  task automatic send(input logic [7:0] op, input logic [15:0] pc, input logic [7:0] a,
                      input logic [7:0] b, input bit rnd_ready);
    @(negedge clk);
    in_opcode = op; in_pc = pc; in_imm_a = a; in_imm_b = b; in_valid = 1'b1;
    out_ready = rnd_ready ? 1'($urandom_range(0, 1)) : 1'b1;
    #0.5;
    while (!in_ready) begin
      @(negedge clk);
      out_ready = rnd_ready ? 1'($urandom_range(0, 1)) : 1'b1;
      #0.5;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    flag_strobe = 1'b0;
  endtask

  task automatic set_flags(input logic q, input logic z, input logic df, input logic ie);
    q_flag = q; acc_zero = z; carry = df; irq_en = ie;
  endtask

  task automatic strobe_ext(input logic [3:0] pins, input bit strobe);
    @(negedge clk);
    ext_flag_n = pins;
    flag_strobe = strobe;
    @(posedge clk);
    #1;
    flag_strobe = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1 out_valid", 32'(out_valid), 32'h0);
    chk("R1 in_ready", 32'(in_ready), 32'h1);
    @(negedge clk);
    rst_n = 1'b1;

    // R3: taken short branch keeps the high byte
    set_flags(0, 0, 0, 0);
    send(8'h30, 16'h12FF, 8'h40, 8'h00, 0);
    chk("R3 short", 32'(out_next_pc), 32'h1240);
    // R4: not-taken short branch carries into the high byte
    send(8'h38, 16'h12FF, 8'h40, 8'h00, 0);
    chk("R4 short", 32'(out_next_pc), 32'h1300);
    // R5: inverted accumulator test
    set_flags(0, 1, 0, 0);
    send(8'h3A, 16'h0500, 8'h77, 8'h00, 0);
    chk("R5 bnz on zero", 32'(out_taken), 32'h0);
    // R6: long branch taken and not taken
    send(8'hC0, 16'h0100, 8'hAB, 8'hCD, 0);
    chk("R6 lbr target", 32'(out_next_pc), 32'hABCD);
    chk("R6 lbr third", 32'(out_third), 32'h1);
    set_flags(0, 0, 0, 0);
    send(8'hC3, 16'hFFFF, 8'hAB, 8'hCD, 0);
    chk("R6 lbdf wrap", 32'(out_next_pc), 32'h0001);
    // R7: long skips
    set_flags(1, 0, 0, 0);
    send(8'hCD, 16'h2000, 8'h00, 8'h00, 0);
    chk("R7 lsq", 32'(out_next_pc), 32'h2002);
    send(8'hC5, 16'h2000, 8'h00, 8'h00, 0);
    chk("R7 lsnq", 32'(out_next_pc), 32'h2000);
    chk("R7 lsnq third", 32'(out_third), 32'h0);
    // R8: no-operation and unrelated opcodes
    send(8'hC4, 16'h3333, 8'h12, 8'h34, 0);
    chk("R8 nop", 32'(out_next_pc), 32'h3333);
    send(8'h7A, 16'h4444, 8'h12, 8'h34, 0);
    chk("R8 other taken", 32'(out_taken), 32'h0);
    // R9: external flag capture gated by strobe
    strobe_ext(4'b1110, 1);
    send(8'h34, 16'h5000, 8'h10, 8'h00, 0);
    chk("R9 ef1 asserted", 32'(out_taken), 32'h1);
    strobe_ext(4'b1111, 0);
    send(8'h34, 16'h5000, 8'h10, 8'h00, 0);
    chk("R9 no strobe", 32'(out_taken), 32'h1);
    strobe_ext(4'b1111, 1);
    send(8'h34, 16'h5000, 8'h10, 8'h00, 0);
    chk("R9 after strobe", 32'(out_taken), 32'h0);

    // R2: hold under back-pressure
    send(8'hC0, 16'h0000, 8'h5A, 8'hA5, 0);
    out_ready = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    chk("R2 held valid", 32'(out_valid), 32'h1);
    chk("R2 held pc", 32'(out_next_pc), 32'h5AA5);
    chk("R2 not ready", 32'(in_ready), 32'h0);

    // exhaustive opcode sweep under every core flag pattern
    for (int fl = 0; fl < 16; fl++) begin
      for (int op = 0; op < 256; op++) begin
        set_flags(fl[0], fl[1], fl[2], fl[3]);
        if ((op % 7) == 0) begin
          ext_flag_n = 4'($urandom);
          flag_strobe = 1'b1;
        end
        send(8'(op), 16'($urandom), 8'($urandom), 8'($urandom), 1);
      end
    end
    // random mix with flag strobes and back-pressure
    for (int i = 0; i < 3000; i++) begin
      set_flags(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      ext_flag_n = 4'($urandom);
      flag_strobe = 1'($urandom);
      send((i % 3 == 0) ? 8'($urandom) : ((i % 3 == 1) ? 8'h30 | 8'($urandom % 16)
                                                       : 8'hC0 | 8'($urandom % 16)),
           16'($urandom), 8'($urandom), 8'($urandom), 1);
    end
    @(negedge clk);
    out_ready = 1'b1;
    repeat (4) @(posedge clk);
    #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    errors++;
    checks++;
    $display("FAIL R2: watchdog expired, got %0d cycles expected fewer", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule